// File: doc/BRIEF.md
# Second-Chance Page Victim Selector

This block keeps resident page frames in the order they were filled and picks one to give up when the memory manager asks for room. When a replacement is requested, the oldest frame is examined first. If that frame has been touched since it last reached the head, it gets a second chance: its referenced flag is cleared and it goes to the back of the line. Otherwise it becomes the victim. One head is examined per clock, so the search walks the order until it finds a frame that has not been touched.

The surrounding logic reports every access as a frame index plus a write flag. It appends a frame to the order once that frame holds a new page. It raises a one-cycle replacement request when a frame is needed. The answer comes back as a one-cycle response that carries the victim index and says whether the victim was written while resident, so the caller knows if the page needs saving first. A request made while nothing is resident is answered with an error and starts no search. Writing pages back and editing page tables are left to the caller.

Top module: `scv_victim_sel`

## Requirements
- R1: After reset, no frame is resident and `rsp_valid` is 0. A replacement request made right after reset is answered with an error.
- R2: A load appends its frame at the tail of the order and clears that frame's referenced and modified flags. A load is dropped when NFRAMES frames are already resident, and also in any cycle in which a head is being examined.
- R3: A reference report sets the referenced flag of `ref_frame`. It also sets the modified flag when `ref_write` is 1.
- R4: Examination starts in the cycle `rep_req` is accepted. A head whose referenced flag is 0 is removed from the order. `rsp_valid` is then high for exactly one cycle, after the clock edge that ends that examination, with `rsp_error`=0 and `rsp_frame` set to the head's index.
- R5: A head whose referenced flag is 1 has the flag cleared and moves to the tail. One head is examined per cycle. With k such heads in a row, the response follows k+1 edges after the request.
- R6: `rsp_dirty` equals the victim's modified flag. Clean victims and dirty victims are both evicted.
- R7: A reference reported in the same cycle as an examination of that frame counts before the examination. This applies to both its referenced and its modified effect.
- R8: A request while no frame is resident gives `rsp_valid`=1 with `rsp_error`=1 after the next edge. The order is left unchanged.
- R9: The examination numbered NFRAMES+1 within one search evicts its head whatever that head's referenced flag is. Every search therefore ends within NFRAMES+1 cycles.
- R10: `rep_req` is ignored while a search is in progress. It produces no additional response.
- R11: An evicted frame leaves the order. When it is loaded again, it is placed at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A frame access is being reported this cycle |
| ref_frame | input | IDXW | Index of the accessed frame |
| ref_write | input | 1 | The reported access is a write |
| load_valid | input | 1 | Append a newly filled frame |
| load_frame | input | IDXW | Index of the frame to append |
| rep_req | input | 1 | Replacement request, one cycle |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_frame | output | IDXW | Victim frame index |
| rsp_dirty | output | 1 | Victim was modified while resident |
| rsp_error | output | 1 | Request found no resident frame |

## Verification
Each pattern is chosen to tell apart two behaviours that would otherwise look the same at the response port. Untouched frames check plain oldest-first order and single-cycle latency. Mixed read and write references check that recycled heads are retained and that a recycled frame can still come back dirty. A fully referenced full order needs every one of the seventeen examinations, and it also shows that a load into a full order is dropped. References that land on the head in the cycle it is examined, a request held through a search, an empty order, and two frames referenced on every cycle of the search separate, in turn, same-cycle priority, the ignored request, the error path, and the forced end of a search. A behavioural queue model is compared with the response port on every clock.

// File: rtl/scv_pkg.sv
package scv_pkg;

  typedef enum logic [1:0] {
    RING_IDLE   = 2'd0,
    RING_PUSH   = 2'd1,
    RING_POP    = 2'd2,
    RING_ROTATE = 2'd3
  } ring_op_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } search_state_e;

endpackage

// File: rtl/scv_order_ring.sv
module scv_order_ring
  import scv_pkg::*;
#(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES),
  parameter int CNTW    = $clog2(NFRAMES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  ring_op_e        op,
  input  logic [IDXW-1:0] push_frame,
  output logic [IDXW-1:0] head_frame,
  output logic [CNTW-1:0] count
);

  localparam logic [IDXW-1:0] LAST_SLOT = IDXW'(NFRAMES - 1);
  localparam logic [CNTW-1:0] FULL_CNT  = CNTW'(NFRAMES);

  logic [IDXW-1:0] slots [NFRAMES];
  logic [IDXW-1:0] head_ptr, tail_ptr;
  logic            wr_en;
  logic [IDXW-1:0] wr_data;
  logic            adv_head, adv_tail;

  assign head_frame = slots[head_ptr];
  assign wr_en      = (op == RING_PUSH) || (op == RING_ROTATE);
  assign wr_data    = (op == RING_ROTATE) ? head_frame : push_frame;
  assign adv_head   = (op == RING_POP) || (op == RING_ROTATE);
  assign adv_tail   = wr_en;

  always_ff @(posedge clk) begin
    if (wr_en) slots[tail_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      if (adv_head) head_ptr <= (head_ptr == LAST_SLOT) ? '0 : head_ptr + 1'b1;
      if (adv_tail) tail_ptr <= (tail_ptr == LAST_SLOT) ? '0 : tail_ptr + 1'b1;
      case (op)
        RING_PUSH: count <= count + 1'b1;
        RING_POP:  count <= count - 1'b1;
        default:   count <= count;
      endcase
    end
  end

  // R2: a push never lands in a full order
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (op == RING_PUSH) |-> (count < FULL_CNT));

  // R4: a head leaves only when something is resident
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    adv_head |-> (count != '0));

  // R5: recycling a head keeps the resident count
  p_rotate_keeps_count_r5: assert property (@(posedge clk) disable iff (rst)
    (op == RING_ROTATE) |=> $stable(count));

endmodule

// File: rtl/scv_flag_bank.sv
module scv_flag_bank #(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_valid,
  input  logic [IDXW-1:0] ref_frame,
  input  logic            ref_write,
  input  logic            load_en,
  input  logic [IDXW-1:0] load_frame,
  input  logic            clr_en,
  input  logic [IDXW-1:0] head_frame,
  output logic            head_ref,
  output logic            head_dirty
);

  logic [NFRAMES-1:0] ref_q, mod_q;
  logic               head_hit;

  for (genvar i = 0; i < NFRAMES; i++) begin : g_flag
    logic hit_i, load_i, clr_i;
    assign hit_i  = ref_valid && (ref_frame == IDXW'(i));
    assign load_i = load_en && (load_frame == IDXW'(i));
    assign clr_i  = clr_en && (head_frame == IDXW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ref_q[i] <= 1'b0;
        mod_q[i] <= 1'b0;
      end else if (load_i) begin
        ref_q[i] <= 1'b0;
        mod_q[i] <= 1'b0;
      end else begin
        ref_q[i] <= (ref_q[i] | hit_i) & ~clr_i;
        mod_q[i] <= mod_q[i] | (hit_i & ref_write);
      end
    end
  end

  // same-cycle reference is seen by the examination
  assign head_hit   = ref_valid && (ref_frame == head_frame);
  assign head_ref   = ref_q[head_frame] | head_hit;
  assign head_dirty = mod_q[head_frame] | (head_hit & ref_write);

  // R3: a write reference leaves the modified flag set unless reloaded
  p_write_marks_r3: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && ref_write && !(load_en && load_frame == ref_frame))
      |=> mod_q[$past(ref_frame)]);

  // R2: a load starts the frame with both flags clear
  p_load_clears_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (!ref_q[$past(load_frame)] && !mod_q[$past(load_frame)]));

endmodule

// File: rtl/scv_search_ctrl.sv
module scv_search_ctrl
  import scv_pkg::*;
#(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES),
  parameter int EXMW    = $clog2(NFRAMES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rep_req,
  input  logic            empty,
  input  logic            head_ref,
  input  logic            head_dirty,
  input  logic [IDXW-1:0] head_frame,
  output logic            examining,
  output logic            evict,
  output logic            rotate,
  output logic            rsp_valid,
  output logic [IDXW-1:0] rsp_frame,
  output logic            rsp_dirty,
  output logic            rsp_error
);

  localparam logic [EXMW-1:0] EXAM_LIMIT = EXMW'(NFRAMES);

  search_state_e   state;
  logic [EXMW-1:0] exam_cnt;
  logic            force_out;
  logic            reject;

  assign examining = (state == ST_SEARCH) || (rep_req && !empty);
  assign force_out = (exam_cnt == EXAM_LIMIT);
  assign evict     = examining && (!head_ref || force_out);
  assign rotate    = examining && !evict;
  assign reject    = (state == ST_IDLE) && rep_req && empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      exam_cnt  <= '0;
      rsp_valid <= 1'b0;
      rsp_frame <= '0;
      rsp_dirty <= 1'b0;
      rsp_error <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (reject) begin
        rsp_valid <= 1'b1;
        rsp_error <= 1'b1;
        rsp_dirty <= 1'b0;
      end else if (evict) begin
        rsp_valid <= 1'b1;
        rsp_error <= 1'b0;
        rsp_frame <= head_frame;
        rsp_dirty <= head_dirty;
        state     <= ST_IDLE;
        exam_cnt  <= '0;
      end else if (rotate) begin
        state     <= ST_SEARCH;
        exam_cnt  <= exam_cnt + 1'b1;
      end
    end
  end

  // R8: an empty order answers with an error on the next edge
  p_empty_error_r8: assert property (@(posedge clk) disable iff (rst)
    reject |=> (rsp_valid && rsp_error));

  // R9: the last allowed examination always ends the search
  p_search_bound_r9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SEARCH) && force_out) |=> (rsp_valid && !rsp_error && state == ST_IDLE));

  // R10: while searching, the request line changes nothing but progress
  p_no_resp_midsearch_r10: assert property (@(posedge clk) disable iff (rst)
    rotate |=> !rsp_valid);

endmodule

// File: rtl/scv_victim_sel.sv
module scv_victim_sel
  import scv_pkg::*;
#(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_valid,
  input  logic [IDXW-1:0] ref_frame,
  input  logic            ref_write,
  input  logic            load_valid,
  input  logic [IDXW-1:0] load_frame,
  input  logic            rep_req,
  output logic            rsp_valid,
  output logic [IDXW-1:0] rsp_frame,
  output logic            rsp_dirty,
  output logic            rsp_error
);

  localparam int CNTW = $clog2(NFRAMES + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(NFRAMES);

  ring_op_e        ring_op;
  logic [IDXW-1:0] head_frame;
  logic [CNTW-1:0] count;
  logic            head_ref, head_dirty;
  logic            examining, evict, rotate, load_en;

  assign load_en = load_valid && !examining && (count < FULL_CNT);

  always_comb begin
    if (evict)        ring_op = RING_POP;
    else if (rotate)  ring_op = RING_ROTATE;
    else if (load_en) ring_op = RING_PUSH;
    else              ring_op = RING_IDLE;
  end

  scv_order_ring #(.NFRAMES(NFRAMES), .IDXW(IDXW), .CNTW(CNTW)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .op         (ring_op),
    .push_frame (load_frame),
    .head_frame (head_frame),
    .count      (count)
  );

  scv_flag_bank #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .ref_valid  (ref_valid),
    .ref_frame  (ref_frame),
    .ref_write  (ref_write),
    .load_en    (load_en),
    .load_frame (load_frame),
    .clr_en     (rotate),
    .head_frame (head_frame),
    .head_ref   (head_ref),
    .head_dirty (head_dirty)
  );

  scv_search_ctrl #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rep_req    (rep_req),
    .empty      (count == '0),
    .head_ref   (head_ref),
    .head_dirty (head_dirty),
    .head_frame (head_frame),
    .examining  (examining),
    .evict      (evict),
    .rotate     (rotate),
    .rsp_valid  (rsp_valid),
    .rsp_frame  (rsp_frame),
    .rsp_dirty  (rsp_dirty),
    .rsp_error  (rsp_error)
  );

  // R4: a victim response always follows an examination
  p_victim_after_exam_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_error) |-> $past(examining));

  // R11: an eviction lowers the resident count by one
  p_evict_removes_r11: assert property (@(posedge clk) disable iff (rst)
    evict |=> (count == $past(count) - 1'b1));

endmodule

// File: tb/test_scv_victim_sel.sv
module test_scv_victim_sel;

  localparam int NF = 16;
  localparam int IW = $clog2(NF);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_valid = 1'b0, ref_write = 1'b0;
  logic [IW-1:0] ref_frame = '0;
  logic          load_valid = 1'b0;
  logic [IW-1:0] load_frame = '0;
  logic          rep_req = 1'b0;
  logic          rsp_valid, rsp_dirty, rsp_error;
  logic [IW-1:0] rsp_frame;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  string cur_tag  = "R1";

  always #10 clk = ~clk;

  scv_victim_sel #(.NFRAMES(NF), .IDXW(IW)) i_scv_victim_sel (
    .clk(clk), .rst(rst),
    .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
    .load_valid(load_valid), .load_frame(load_frame),
    .rep_req(rep_req),
    .rsp_valid(rsp_valid), .rsp_frame(rsp_frame),
    .rsp_dirty(rsp_dirty), .rsp_error(rsp_error)
  );

  // behavioural reference model
  int q[$];
  bit refb[NF];
  bit modb[NF];
  bit m_search;
  int m_exam;
  bit e_valid, e_err, e_dirty;
  int e_frame;
  int h;
  bit exam, errc;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      for (int i = 0; i < NF; i++) begin refb[i] = 0; modb[i] = 0; end
      m_search = 0; m_exam = 0; e_valid = 0; e_err = 0;
    end else begin
      exam = m_search || (rep_req && q.size() != 0);
      errc = !m_search && rep_req && q.size() == 0;
      e_valid = 0;
      if (ref_valid) begin
        refb[ref_frame] = 1;
        if (ref_write) modb[ref_frame] = 1;
      end
      if (errc) begin e_valid = 1; e_err = 1; end
      if (exam) begin
        h = q[0];
        void'(q.pop_front());
        if (!refb[h] || m_exam == NF) begin
          e_valid = 1; e_err = 0; e_frame = h; e_dirty = modb[h];
          m_search = 0; m_exam = 0;
        end else begin
          refb[h] = 0;
          q.push_back(h);
          m_search = 1; m_exam++;
        end
      end else if (load_valid && q.size() < NF) begin
        q.push_back(int'(load_frame));
        refb[load_frame] = 0; modb[load_frame] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if (rsp_valid !== e_valid ||
          (e_valid && (rsp_error !== e_err ||
                       (!e_err && (int'(rsp_frame) != e_frame || rsp_dirty !== e_dirty))))) begin
        n_fails++;
        $display("FAIL %s model: got v=%0b f=%0d d=%0b e=%0b, expected v=%0b f=%0d d=%0b e=%0b",
                 cur_tag, rsp_valid, rsp_frame, rsp_dirty, rsp_error,
                 e_valid, e_frame, e_dirty, e_err);
      end
    end
  end

  task automatic do_load(input int f);
    load_valid = 1'b1; load_frame = IW'(f);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic do_ref(input int f, input bit w);
    ref_valid = 1'b1; ref_frame = IW'(f); ref_write = w;
    @(negedge clk);
    ref_valid = 1'b0; ref_write = 1'b0;
  endtask

  task automatic do_req(input int ef, input bit ed, input bit ee, input int elat, input string tag);
    int lat;
    cur_tag = tag;
    rep_req = 1'b1;
    @(negedge clk);
    rep_req = 1'b0; ref_valid = 1'b0; ref_write = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    n_checks++;
    if (!rsp_valid || rsp_error !== ee || lat != elat ||
        (!ee && (int'(rsp_frame) != ef || rsp_dirty !== ed))) begin
      n_fails++;
      $display("FAIL %s: got v=%0b f=%0d d=%0b e=%0b lat=%0d, expected f=%0d d=%0b e=%0b lat=%0d",
               tag, rsp_valid, rsp_frame, rsp_dirty, rsp_error, lat, ef, ed, ee, elat);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got no end of run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rsp_valid === 1'b0, "R1", $sformatf("reset rsp_valid got %0b expected 0", rsp_valid));
    // R1, R8: empty order after reset
    do_req(0, 0, 1, 1, "R1");
    @(negedge clk);
    // R2, R4: plain oldest-first
    for (int f = 0; f < 4; f++) do_load(f);
    do_req(0, 0, 0, 1, "R4");
    // R5, R6: recycled heads, dirty tracking
    do_ref(1, 0);
    do_ref(2, 1);
    do_req(3, 0, 0, 3, "R5");
    do_req(1, 0, 0, 1, "R5");
    do_req(2, 1, 0, 1, "R6");
    do_req(0, 0, 1, 1, "R8");
    // R2: full order, extra load dropped; all referenced
    for (int f = 0; f < NF; f++) do_load(f);
    do_load(5);
    for (int f = 0; f < NF; f++) do_ref(f, 0);
    do_req(0, 0, 0, NF + 1, "R5");
    // R11: reload evicted frame at tail
    do_load(0);
    do_req(1, 0, 0, 1, "R11");
    // R7: same-cycle write reference on the head
    ref_valid = 1'b1; ref_frame = IW'(2); ref_write = 1'b1;
    do_req(3, 0, 0, 2, "R7");
    // R2: a load during a search is dropped
    do_ref(4, 0);
    cur_tag = "R2";
    rep_req = 1'b1; load_valid = 1'b1; load_frame = IW'(3);
    @(negedge clk);
    rep_req = 1'b0; load_valid = 1'b0;
    chk(rsp_valid === 1'b0, "R2", "response one cycle early");
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_frame == IW'(5), "R2",
        $sformatf("got v=%0b f=%0d expected v=1 f=5", rsp_valid, rsp_frame));
    // R10: request held through a search
    do_ref(6, 0);
    cur_tag = "R10";
    rep_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rep_req = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_frame == IW'(7), "R10",
        $sformatf("got v=%0b f=%0d expected v=1 f=7", rsp_valid, rsp_frame));
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10", $sformatf("extra response got v=%0b expected 0", rsp_valid));
    // R9: two frames referenced every cycle of the search
    cur_tag = "R9";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_load(3);
    do_load(9);
    for (int k = 0; k <= NF; k++) begin
      ref_valid = 1'b1; ref_write = 1'b0;
      ref_frame = (k % 2 == 0) ? IW'(3) : IW'(9);
      rep_req = (k == 0);
      @(negedge clk);
      if (k < NF)
        chk(rsp_valid === 1'b0, "R9", $sformatf("early response at step %0d", k));
    end
    ref_valid = 1'b0; rep_req = 1'b0;
    chk(rsp_valid === 1'b1 && !rsp_error && rsp_frame == IW'(3), "R9",
        $sformatf("got v=%0b f=%0d e=%0b expected v=1 f=3 e=0", rsp_valid, rsp_frame, rsp_error));
    // R3: the remaining frame has flags cleared by its recycles; a write marks it
    @(negedge clk);
    do_ref(9, 1);
    do_req(9, 1, 0, 2, "R3");
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule